// File: doc/BRIEF.md
# Load Extender and Store Lane Aligner

This block sits between a 64-bit naturally aligned memory bus and a 64-bit register file. It has two independent paths, and each registers its result one clock after a valid input. The load path receives the full bus word, the byte offset inside that word and a 3-bit access code. It moves the addressed byte, halfword, word or doubleword down to bit 0. It then fills the upper bits with copies of the sign bit or with zeros, as the access code asks.

The store path receives a source register value, a byte offset and an access code. It copies the low bytes of the source across every lane of the bus word that could hold them. It also produces one byte-enable bit per lane, so the bus writes only the addressed bytes.

Neither path handles an access that crosses its natural boundary. The block raises a misalignment flag for such an access, and on a store it also withholds every byte enable.

Top module: `mem_lane_unit`

## Requirements
- R1: After reset, every output is zero: both valid flags, both data words, the byte enables and both misalignment flags.
- R2: `ld_valid_o` and `st_valid_o` equal the matching valid input of the previous clock. Each result appears on the clock after its valid input.
- R3: A load shifts the bus word right by 8 times `ld_off_i` before it selects and extends the low bytes.
- R4: Load codes 000 (byte), 001 (halfword) and 010 (word) copy the top bit of the selected 8, 16 or 32 bits into every higher bit.
- R5: Load codes 100 (byte), 101 (halfword) and 110 (word) clear every bit above the selected 8, 16 or 32 bits.
- R6: Load codes 011 and 111 return the shifted 64-bit word unchanged. Bit 2 of the code has no effect when bits 1:0 are 11.
- R7: The store data is the low 8, 16, 32 or 64 bits of `st_src_i`, selected by `st_kind_i[1:0]` (00, 01, 10, 11). It is repeated 8, 4, 2 or 1 times across the bus word. `st_kind_i[2]` is ignored.
- R8: On an aligned store, `st_be_o` is 0x01, 0x03, 0x0F or 0xFF for sizes 00 to 11, shifted left by `st_off_i`.
- R9: The misalignment flag of each path is set when the offset is not a multiple of the access size in bytes (1, 2, 4 or 8, from code bits 1:0).
- R10: On a misaligned store, `st_be_o` is all zero.
- R11: While a valid input is low, the data, byte-enable and misalignment outputs of that path keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Load request present |
| ld_word_i | input | 64 | Aligned word read from memory |
| ld_off_i | input | 3 | Byte offset of the load in the word |
| ld_kind_i | input | 3 | Load size and signedness code |
| st_valid_i | input | 1 | Store request present |
| st_src_i | input | 64 | Source register value |
| st_off_i | input | 3 | Byte offset of the store in the word |
| st_kind_i | input | 3 | Store size code (bit 2 ignored) |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 64 | Extended load result |
| ld_misalign_o | output | 1 | Load offset not aligned to its size |
| st_valid_o | output | 1 | Store lanes valid |
| st_data_o | output | 64 | Store data replicated onto lanes |
| st_be_o | output | 8 | Byte-enable mask |
| st_misalign_o | output | 1 | Store offset not aligned to its size |

## Verification
The bench builds the block with its default 64-bit data width, which gives eight byte lanes and a 3-bit offset. With that width, every pair of offset and access code can be reached, including the reserved code 111 and the doubleword at a nonzero offset. A run of random requests, with idle gaps between some of them, reaches the sign fill at every lane and the hold behaviour. The same run produces every mask shape at every legal offset.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    // Access size, taken from the low two bits of the access code
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    // Bit 2 of the access code marks a zero-filling load
    localparam int unsigned KIND_UNS_BIT = 2;

    function automatic acc_size_e kind_to_size(input logic [2:0] kind);
        return acc_size_e'(kind[1:0]);
    endfunction

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
    import lsu_lane_pkg::*;
#(
    parameter int unsigned OFF_W = 3
) (
    input  logic [OFF_W-1:0] off_i,
    input  acc_size_e        size_i,
    output logic             misalign_o
);
    localparam int unsigned MW = (OFF_W > 3) ? OFF_W : 3;

    logic [MW-1:0] low_mask;
    logic [MW-1:0] off_ext;

    always_comb begin
        off_ext = MW'(off_i);
        unique case (size_i)
            SZ_BYTE:  low_mask = MW'(0);
            SZ_HALF:  low_mask = MW'(1);
            SZ_WORD:  low_mask = MW'(3);
            default:  low_mask = MW'(7);
        endcase
        misalign_o = |(off_ext & low_mask);
    end
endmodule

// File: rtl/load_extend.sv
module load_extend
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0]                 word_i,
    input  logic [$clog2(DATA_W/8)-1:0]       off_i,
    input  logic [2:0]                        kind_i,
    output logic [DATA_W-1:0]                 data_o
);
    localparam int unsigned NB    = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(NB);

    logic [DATA_W-1:0] shifted;
    logic              fill;
    logic              unsigned_ld;
    acc_size_e         size;

    always_comb begin
        shifted     = word_i >> {off_i, 3'b000};
        size        = kind_to_size(kind_i);
        unsigned_ld = kind_i[KIND_UNS_BIT];
        fill        = 1'b0;
        data_o      = shifted;
        unique case (size)
            SZ_BYTE: begin
                fill   = ~unsigned_ld & shifted[7];
                data_o = {{(DATA_W-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill   = ~unsigned_ld & shifted[15];
                data_o = {{(DATA_W-16){fill}}, shifted[15:0]};
            end
            SZ_WORD: begin
                fill   = ~unsigned_ld & shifted[31];
                data_o = {{(DATA_W-32){fill}}, shifted[31:0]};
            end
            default: begin
                data_o = shifted;
            end
        endcase
    end
endmodule

// File: rtl/store_align.sv
module store_align
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0]             src_i,
    input  logic [$clog2(DATA_W/8)-1:0]   off_i,
    input  acc_size_e                     size_i,
    input  logic                          misalign_i,
    output logic [DATA_W-1:0]             data_o,
    output logic [DATA_W/8-1:0]           be_o
);
    localparam int unsigned NB    = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(NB);

    logic [2*NB-1:0] mask_wide;
    logic [2*NB-1:0] base_mask;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                data_o    = {(NB){src_i[7:0]}};
                base_mask = (2*NB)'(8'h01);
            end
            SZ_HALF: begin
                data_o    = {(NB/2){src_i[15:0]}};
                base_mask = (2*NB)'(8'h03);
            end
            SZ_WORD: begin
                data_o    = {(NB/4){src_i[31:0]}};
                base_mask = (2*NB)'(8'h0F);
            end
            default: begin
                data_o    = src_i;
                base_mask = (2*NB)'(8'hFF);
            end
        endcase
        mask_wide = base_mask << off_i;
        be_o      = misalign_i ? '0 : mask_wide[NB-1:0];
    end
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
    import lsu_lane_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_valid_i,
    input  logic [DATA_W-1:0]             ld_word_i,
    input  logic [$clog2(DATA_W/8)-1:0]   ld_off_i,
    input  logic [2:0]                    ld_kind_i,
    input  logic                          st_valid_i,
    input  logic [DATA_W-1:0]             st_src_i,
    input  logic [$clog2(DATA_W/8)-1:0]   st_off_i,
    input  logic [2:0]                    st_kind_i,
    output logic                          ld_valid_o,
    output logic [DATA_W-1:0]             ld_data_o,
    output logic                          ld_misalign_o,
    output logic                          st_valid_o,
    output logic [DATA_W-1:0]             st_data_o,
    output logic [DATA_W/8-1:0]           st_be_o,
    output logic                          st_misalign_o
);
    localparam int unsigned NB    = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(NB);

    typedef struct packed {
        logic              ld_vld;
        logic [DATA_W-1:0] ld_data;
        logic              ld_mis;
        logic              st_vld;
        logic [DATA_W-1:0] st_data;
        logic [NB-1:0]     st_be;
        logic              st_mis;
    } lane_state_t;

    lane_state_t state_d, state_q;

    logic [DATA_W-1:0] ld_ext;
    logic [DATA_W-1:0] st_lanes;
    logic [NB-1:0]     st_mask;
    logic              ld_mis_c;
    logic              st_mis_c;

    load_extend #(.DATA_W(DATA_W)) u_ld_ext (
        .word_i (ld_word_i),
        .off_i  (ld_off_i),
        .kind_i (ld_kind_i),
        .data_o (ld_ext)
    );

    lane_align_check #(.OFF_W(OFF_W)) u_ld_chk (
        .off_i      (ld_off_i),
        .size_i     (kind_to_size(ld_kind_i)),
        .misalign_o (ld_mis_c)
    );

    lane_align_check #(.OFF_W(OFF_W)) u_st_chk (
        .off_i      (st_off_i),
        .size_i     (kind_to_size(st_kind_i)),
        .misalign_o (st_mis_c)
    );

    store_align #(.DATA_W(DATA_W)) u_st_aln (
        .src_i      (st_src_i),
        .off_i      (st_off_i),
        .size_i     (kind_to_size(st_kind_i)),
        .misalign_i (st_mis_c),
        .data_o     (st_lanes),
        .be_o       (st_mask)
    );

    always_comb begin
        state_d        = state_q;
        state_d.ld_vld = ld_valid_i;
        state_d.st_vld = st_valid_i;
        if (ld_valid_i) begin
            state_d.ld_data = ld_ext;
            state_d.ld_mis  = ld_mis_c;
        end
        if (st_valid_i) begin
            state_d.st_data = st_lanes;
            state_d.st_be   = st_mask;
            state_d.st_mis  = st_mis_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ld_valid_o    = state_q.ld_vld;
    assign ld_data_o     = state_q.ld_data;
    assign ld_misalign_o = state_q.ld_mis;
    assign st_valid_o    = state_q.st_vld;
    assign st_data_o     = state_q.st_data;
    assign st_be_o       = state_q.st_be;
    assign st_misalign_o = state_q.st_mis;
endmodule

// File: rtl/mem_lane_unit_chk.sv
module mem_lane_unit_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ld_valid_i,
    input logic [$clog2(DATA_W/8)-1:0]   ld_off_i,
    input logic [2:0]                    ld_kind_i,
    input logic                          st_valid_i,
    input logic [$clog2(DATA_W/8)-1:0]   st_off_i,
    input logic [2:0]                    st_kind_i,
    input logic                          ld_valid_o,
    input logic [DATA_W-1:0]             ld_data_o,
    input logic                          st_valid_o,
    input logic [DATA_W/8-1:0]           st_be_o,
    input logic                          st_misalign_o
);
    a_r2_ld_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> ld_valid_o);

    a_r2_st_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_i |=> st_valid_o);

    a_r5_ubyte_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && ld_kind_i == 3'b100) |=> (ld_data_o[DATA_W-1:8] == '0));

    a_r9_dword_offset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_kind_i[1:0] == 2'b11 && st_off_i != '0) |=> st_misalign_o);

    a_r10_misaligned_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && st_misalign_o) |-> (st_be_o == '0));

    a_r8_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && !st_misalign_o) |-> ($countones(st_be_o) == 1 || $countones(st_be_o) == 2 ||
                                            $countones(st_be_o) == 4 || $countones(st_be_o) == 8));

    a_r11_ld_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> $stable(ld_data_o));

    a_r11_st_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid_i |=> $stable(st_be_o));
endmodule

bind mem_lane_unit mem_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_valid_i    (ld_valid_i),
    .ld_off_i      (ld_off_i),
    .ld_kind_i     (ld_kind_i),
    .st_valid_i    (st_valid_i),
    .st_off_i      (st_off_i),
    .st_kind_i     (st_kind_i),
    .ld_valid_o    (ld_valid_o),
    .ld_data_o     (ld_data_o),
    .st_valid_o    (st_valid_o),
    .st_be_o       (st_be_o),
    .st_misalign_o (st_misalign_o)
);

// File: tb/tb_mem_lane_unit.sv
`timescale 1ns/1ps
module tb_mem_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid_i = 1'b0;
    logic [63:0] ld_word_i = '0;
    logic [2:0]  ld_off_i = '0;
    logic [2:0]  ld_kind_i = '0;
    logic        st_valid_i = 1'b0;
    logic [63:0] st_src_i = '0;
    logic [2:0]  st_off_i = '0;
    logic [2:0]  st_kind_i = '0;
    logic        ld_valid_o;
    logic [63:0] ld_data_o;
    logic        ld_misalign_o;
    logic        st_valid_o;
    logic [63:0] st_data_o;
    logic [7:0]  st_be_o;
    logic        st_misalign_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mem_lane_unit dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid_i(ld_valid_i), .ld_word_i(ld_word_i), .ld_off_i(ld_off_i), .ld_kind_i(ld_kind_i),
        .st_valid_i(st_valid_i), .st_src_i(st_src_i), .st_off_i(st_off_i), .st_kind_i(st_kind_i),
        .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o), .ld_misalign_o(ld_misalign_o),
        .st_valid_o(st_valid_o), .st_data_o(st_data_o), .st_be_o(st_be_o), .st_misalign_o(st_misalign_o)
    );

    // Reference state, advanced at each rising edge
    logic        e_ld_vld, e_ld_mis, e_st_vld, e_st_mis;
    logic [63:0] e_ld_data, e_st_data;
    logic [7:0]  e_st_be;
    string       t_ld, t_st, t_be;

    function automatic logic [63:0] ref_load(logic [63:0] w, int off, logic [2:0] kind);
        logic [63:0] sh, r;
        int nb;
        logic [7:0] fb;
        sh = w >> (8 * off);
        nb = 1 << kind[1:0];
        fb = (!kind[2] && nb < 8) ? {8{sh[8*nb-1]}} : 8'h00;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = (i < nb) ? sh[8*i +: 8] : fb;
        return r;
    endfunction

    always @(posedge clk) begin
        int nb, off;
        if (!rst_n) begin
            e_ld_vld = 0; e_ld_mis = 0; e_st_vld = 0; e_st_mis = 0;
            e_ld_data = '0; e_st_data = '0; e_st_be = '0;
            t_ld = "R1"; t_st = "R1"; t_be = "R1";
        end else begin
            e_ld_vld = ld_valid_i;
            e_st_vld = st_valid_i;
            if (ld_valid_i) begin
                off = ld_off_i;
                nb = 1 << ld_kind_i[1:0];
                e_ld_data = ref_load(ld_word_i, off, ld_kind_i);
                e_ld_mis  = (off % nb) != 0;
                if (nb == 8) t_ld = "R6";
                else if (off != 0) t_ld = "R3";
                else if (ld_kind_i[2]) t_ld = "R5";
                else t_ld = "R4";
            end else t_ld = "R11";
            if (st_valid_i) begin
                off = st_off_i;
                nb = 1 << st_kind_i[1:0];
                e_st_mis = (off % nb) != 0;
                for (int i = 0; i < 8; i++) begin
                    e_st_data[8*i +: 8] = st_src_i[8*(i % nb) +: 8];
                    e_st_be[i] = !e_st_mis && i >= off && i < off + nb;
                end
                t_st = "R7";
                t_be = e_st_mis ? "R10" : "R8";
            end else begin
                t_st = "R11"; t_be = "R11";
            end
        end
    end

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp, string what);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", 64'(ld_valid_o), 64'(e_ld_vld), "ld_valid");
        chk("R2", 64'(st_valid_o), 64'(e_st_vld), "st_valid");
        chk(t_ld, ld_data_o, e_ld_data, "ld_data");
        chk(t_ld == "R11" ? "R11" : "R9", 64'(ld_misalign_o), 64'(e_ld_mis), "ld_misalign");
        chk(t_st, st_data_o, e_st_data, "st_data");
        chk(t_be, 64'(st_be_o), 64'(e_st_be), "st_be");
        chk(t_st == "R11" ? "R11" : "R9", 64'(st_misalign_o), 64'(e_st_mis), "st_misalign");
    endtask

    task automatic apply(bit lv, logic [63:0] w, logic [2:0] lo, logic [2:0] lk,
                         bit sv, logic [63:0] s, logic [2:0] so, logic [2:0] sk);
        ld_valid_i = lv; ld_word_i = w; ld_off_i = lo; ld_kind_i = lk;
        st_valid_i = sv; st_src_i = s; st_off_i = so; st_kind_i = sk;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all();              // R1 reset values
        rst_n = 1'b1;
        // Directed corners
        apply(1, 64'h8877_6655_4433_2211, 3'd7, 3'b000, 1, 64'h0123_4567_89AB_CDEF, 3'd7, 3'b000);
        apply(1, 64'h8877_6655_4433_2211, 3'd7, 3'b100, 1, 64'h0123_4567_89AB_CDEF, 3'd6, 3'b001);
        apply(1, 64'h8877_6655_4433_2211, 3'd4, 3'b010, 1, 64'h0123_4567_89AB_CDEF, 3'd4, 3'b010);
        apply(1, 64'h8877_6655_4433_2211, 3'd4, 3'b110, 1, 64'h0123_4567_89AB_CDEF, 3'd0, 3'b011);
        apply(1, 64'hF0E1_D2C3_B4A5_9687, 3'd0, 3'b011, 1, 64'h0123_4567_89AB_CDEF, 3'd0, 3'b111);
        apply(1, 64'hF0E1_D2C3_B4A5_9687, 3'd0, 3'b111, 1, 64'h0123_4567_89AB_CDEF, 3'd3, 3'b011);
        apply(1, 64'hF0E1_D2C3_B4A5_9687, 3'd6, 3'b001, 1, 64'h0123_4567_89AB_CDEF, 3'd1, 3'b001);
        apply(1, 64'hF0E1_D2C3_B4A5_9687, 3'd3, 3'b010, 1, 64'h0123_4567_89AB_CDEF, 3'd2, 3'b010);
        apply(0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 3'b000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 3'b000);
        apply(0, 64'h0, 3'd0, 3'b011, 0, 64'h0, 3'd0, 3'b011);
        // Random traffic with idle gaps
        for (int n = 0; n < 2000; n++) begin
            apply(($urandom % 4) != 0, {$urandom, $urandom}, 3'($urandom), 3'($urandom),
                  ($urandom % 4) != 0, {$urandom, $urandom}, 3'($urandom), 3'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 50000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule